// File: doc/BRIEF.md
# Panel Controller Register and Interrupt Unit

This block is the software-visible face of a simple display panel controller. It keeps six 32-bit registers on a plain synchronous bus: one control word, three timing words, a status word and a subpanel word. It hands the stored panel geometry and mode settings to the rest of the controller. It also merges three sticky event flags into one level-sensitive interrupt line.

A frame sequencer sits beside the block. A control write that turns the panel on sends the sequencer a one-cycle start pulse. The sequencer reports back on three event inputs: frame finished, palette loaded and synchronisation error. A control write that turns the panel off sets the frame-finished flag by itself, unless the palette-only load mode is chosen. The same write clears the synchronisation error. Pixel fetching and the display pipeline sit outside this block.

Top module: `pnl_regbank`

## Requirements
- R1: While reset is low, all state is cleared: flags, stored fields, width and height. After reset, reads return: control 0xFE000C34, timing0 0x000003FF, timing1 0x000003FF, timing2 0xFC000000, status 0, subpanel 0. The irq, seq_start and bus_err outputs are low.
- R2: Control (offset 0x00) write fields are: load mode in bits 21:20, panel-type flag in bit 7, interrupt enables in bits 4:3, mono flag in bit 1 and enable in bit 0. Any other written bit is kept only where the mask 0x01CFF300 is set. A read returns these fields in the same places, ORs the panel-type flag into bit 23 as well, ORs the kept bits in, and ORs the whole word with 0xFE000C34. The fields also drive the cfg_* outputs.
- R3: In timing0 (0x04) and timing1 (0x08), bits 9:0 hold the size minus one and bits 31:10 are stored as written. cfg_width and cfg_height show the field plus one. A timing0 read has bits 3:0 forced to 1. Both reads return the size minus one, truncated to 10 bits, in bits 9:0.
- R4: Timing2 (0x0C) stores all 32 bits. A read has bits 31:26 forced to 1.
- R5: Status (0x10) reads return the palette-loaded flag in bit 6, the sync-error flag in bit 2 and the frame-done flag in bit 0. Writes to status change nothing.
- R6: Subpanel (0x14) stores the written word ANDed with 0xA1FFFFFF.
- R7: A high ev_frame_done, ev_palette_done or ev_sync_error input in a cycle sets its flag at that clock edge. The flag then stays set. An event input wins over any clear caused by a write in the same cycle.
- R8: irq is high when any of these holds: frame-done is set with enable bit 0 (control bit 3) set; palette-loaded is set with enable bit 1 (control bit 4) set; sync-error is set, whatever the enables are. Otherwise irq is low.
- R9: A control write that changes enable from 1 to 0 clears the sync-error flag. It also sets frame-done, unless the load mode in that same write equals 1.
- R10: A control write that changes enable from 0 to 1 clears frame-done and palette-loaded. seq_start is then high for exactly one cycle, in the cycle after the write. A control write that leaves enable unchanged causes neither effect.
- R11: An access to an address that is not word-aligned, or that lies above 0x14, reads as zero and changes no state. bus_err is high for one cycle after each such access.
- R12: bus_rdata is registered. It shows the read result in the cycle after a read request and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after a bad-address access |
| ev_frame_done | input | 1 | Sequencer event: frame finished |
| ev_palette_done | input | 1 | Sequencer event: palette loaded |
| ev_sync_error | input | 1 | Sequencer event: synchronisation error |
| seq_start | output | 1 | One-cycle pulse when the panel is turned on |
| irq | output | 1 | Level interrupt |
| cfg_enable | output | 1 | Stored enable |
| cfg_load_mode | output | 2 | Stored load mode |
| cfg_tft | output | 1 | Stored panel-type flag |
| cfg_mono | output | 1 | Stored mono flag |
| cfg_width | output | 11 | Panel width (field plus one) |
| cfg_height | output | 11 | Panel height (field plus one) |

## Verification
Every result of a request sampled at a clock edge is due in the very next cycle. This covers register contents, cfg_* outputs, flags, irq, seq_start, bus_err and bus_rdata. irq follows the flags with no added cycle. The bench drives inputs on the falling edge and advances its reference model on the rising edge. It compares every output against that model at the following falling edge, so each expected value lines up with the exact cycle the result is due. Directed reads also check literal values worked out from the requirements, including the cases where a write and an event land in the same cycle.

// File: rtl/pnl_pkg.sv
package pnl_pkg;
  localparam int REG_N = 6;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_TIM0 = 3'd1,
    SEL_TIM1 = 3'd2,
    SEL_TIM2 = 3'd3,
    SEL_STAT = 3'd4,
    SEL_SUB  = 3'd5
  } reg_sel_e;

  localparam logic [31:0] CTRL_RD_ONES = 32'hFE000C34;
  localparam logic [31:0] CTRL_KEEP    = 32'h01CFF300;
  localparam logic [31:0] TIM0_RD_ONES = 32'h0000000F;
  localparam logic [31:0] TIM2_RD_ONES = 32'hFC000000;
  localparam logic [31:0] SUB_KEEP     = 32'hA1FFFFFF;
  localparam logic [1:0]  MODE_PAL_ONLY = 2'd1;

  typedef struct packed {
    logic [1:0]  mode;
    logic        tft;
    logic [1:0]  irq_en;
    logic        mono;
    logic        en;
    logic [31:0] extra;
  } ctrl_t;
endpackage

// File: rtl/pnl_bus_dec.sv
module pnl_bus_dec
  import pnl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output logic [REG_N-1:0]  sel,
  output logic              bad
);
  for (genvar i = 0; i < REG_N; i++) begin : g_sel
    assign sel[i] = req && (addr == ADDR_W'(i * 4));
  end

  assign bad = req && !(|sel);
endmodule

// File: rtl/pnl_cfg_regs.sv
module pnl_cfg_regs
  import pnl_pkg::*;
#(
  parameter int DIM_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_N-1:0] wr_sel,
  input  logic [31:0]      wdata,
  output ctrl_t            ctrl_q,
  output logic [31-DIM_W:0] t0_hi_q,
  output logic [31-DIM_W:0] t1_hi_q,
  output logic [DIM_W:0]   width_q,
  output logic [DIM_W:0]   height_q,
  output logic [31:0]      t2_q,
  output logic [31:0]      sub_q,
  output logic             en_rise,
  output logic             en_fall,
  output logic             fall_sets_done,
  output logic             start_q
);
  ctrl_t ctrl_n;
  logic  wr_ctrl;

  assign wr_ctrl = wr_sel[int'(SEL_CTRL)];

  always_comb begin
    ctrl_n        = ctrl_q;
    ctrl_n.mode   = wdata[21:20];
    ctrl_n.tft    = wdata[7];
    ctrl_n.irq_en = wdata[4:3];
    ctrl_n.mono   = wdata[1];
    ctrl_n.en     = wdata[0];
    ctrl_n.extra  = wdata & CTRL_KEEP;
  end

  assign en_rise        = wr_ctrl && wdata[0] && !ctrl_q.en;
  assign en_fall        = wr_ctrl && !wdata[0] && ctrl_q.en;
  assign fall_sets_done = en_fall && (wdata[21:20] != MODE_PAL_ONLY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      t0_hi_q  <= '0;
      t1_hi_q  <= '0;
      width_q  <= '0;
      height_q <= '0;
      t2_q     <= '0;
      sub_q    <= '0;
      start_q  <= 1'b0;
    end else begin
      start_q <= en_rise;
      if (wr_ctrl) ctrl_q <= ctrl_n;
      if (wr_sel[int'(SEL_TIM0)]) begin
        t0_hi_q <= wdata[31:DIM_W];
        width_q <= (DIM_W+1)'(wdata[DIM_W-1:0]) + (DIM_W+1)'(1);
      end
      if (wr_sel[int'(SEL_TIM1)]) begin
        t1_hi_q  <= wdata[31:DIM_W];
        height_q <= (DIM_W+1)'(wdata[DIM_W-1:0]) + (DIM_W+1)'(1);
      end
      if (wr_sel[int'(SEL_TIM2)]) t2_q  <= wdata;
      if (wr_sel[int'(SEL_SUB)])  sub_q <= wdata & SUB_KEEP;
    end
  end

  // R10: the start pulse never lasts two cycles
  p_start_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  // R10: the start pulse follows a turn-on
  p_start_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> ctrl_q.en);
endmodule

// File: rtl/pnl_status_irq.sv
module pnl_status_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_frame,
  input  logic       ev_pal,
  input  logic       ev_sync,
  input  logic       en_rise,
  input  logic       en_fall,
  input  logic       fall_sets_done,
  input  logic [1:0] irq_en,
  output logic       done_q,
  output logic       pal_q,
  output logic       sync_q,
  output logic       irq
);
  logic done_n, pal_n, sync_n;

  always_comb begin
    done_n = done_q;
    pal_n  = pal_q;
    sync_n = sync_q;
    if (en_rise) begin
      done_n = 1'b0;
      pal_n  = 1'b0;
    end
    if (en_fall)        sync_n = 1'b0;
    if (fall_sets_done) done_n = 1'b1;
    done_n = done_n | ev_frame;
    pal_n  = pal_n  | ev_pal;
    sync_n = sync_n | ev_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      pal_q  <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      done_q <= done_n;
      pal_q  <= pal_n;
      sync_q <= sync_n;
    end
  end

  assign irq = (done_q && irq_en[0]) || (pal_q && irq_en[1]) || sync_q;

  // R7: frame-done stays set until a turn-on write
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !en_rise |=> done_q);
  // R7: an event always leaves its flag set
  p_sync_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sync |=> sync_q);
  // R9: turn-off clears sync error unless an event arrives with it
  p_fall_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall && !ev_sync |=> !sync_q);
  // R9: turn-off outside palette-only mode sets frame-done
  p_fall_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fall_sets_done |=> done_q);
  // R10: turn-on clears the palette flag when no event arrives with it
  p_rise_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise && !ev_pal |=> !pal_q);
endmodule

// File: rtl/pnl_regbank.sv
module pnl_regbank
  import pnl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DIM_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  input  logic              ev_frame_done,
  input  logic              ev_palette_done,
  input  logic              ev_sync_error,
  output logic              seq_start,
  output logic              irq,
  output logic              cfg_enable,
  output logic [1:0]        cfg_load_mode,
  output logic              cfg_tft,
  output logic              cfg_mono,
  output logic [DIM_W:0]    cfg_width,
  output logic [DIM_W:0]    cfg_height
);
  logic [REG_N-1:0]  sel;
  logic [REG_N-1:0]  wr_sel;
  logic              bad;
  ctrl_t             ctrl_q;
  logic [31-DIM_W:0] t0_hi_q, t1_hi_q;
  logic [DIM_W:0]    width_q, height_q, wm1, hm1;
  logic [31:0]       t2_q, sub_q;
  logic              en_rise, en_fall, fall_sets_done;
  logic              done_q, pal_q, sync_q;
  logic              rd_req;
  logic [31:0]       rd_val, rdata_n, rdata_q;
  logic              err_q;

  pnl_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
    .req (bus_req),
    .addr(bus_addr),
    .sel (sel),
    .bad (bad)
  );

  assign wr_sel = bus_we ? sel : '0;
  assign rd_req = bus_req && !bus_we;

  pnl_cfg_regs #(.DIM_W(DIM_W)) u_cfg (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_sel        (wr_sel),
    .wdata         (bus_wdata),
    .ctrl_q        (ctrl_q),
    .t0_hi_q       (t0_hi_q),
    .t1_hi_q       (t1_hi_q),
    .width_q       (width_q),
    .height_q      (height_q),
    .t2_q          (t2_q),
    .sub_q         (sub_q),
    .en_rise       (en_rise),
    .en_fall       (en_fall),
    .fall_sets_done(fall_sets_done),
    .start_q       (seq_start)
  );

  pnl_status_irq u_stat (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_frame      (ev_frame_done),
    .ev_pal        (ev_palette_done),
    .ev_sync       (ev_sync_error),
    .en_rise       (en_rise),
    .en_fall       (en_fall),
    .fall_sets_done(fall_sets_done),
    .irq_en        (ctrl_q.irq_en),
    .done_q        (done_q),
    .pal_q         (pal_q),
    .sync_q        (sync_q),
    .irq           (irq)
  );

  assign wm1 = width_q  - (DIM_W+1)'(1);
  assign hm1 = height_q - (DIM_W+1)'(1);

  always_comb begin
    rd_val = '0;
    if (sel[int'(SEL_CTRL)])
      rd_val = (32'(ctrl_q.tft) << 23) | (32'(ctrl_q.mode) << 20) |
               (32'(ctrl_q.tft) << 7)  | (32'(ctrl_q.irq_en) << 3) |
               (32'(ctrl_q.mono) << 1) | 32'(ctrl_q.en) |
               ctrl_q.extra | CTRL_RD_ONES;
    if (sel[int'(SEL_TIM0)]) rd_val = {t0_hi_q, wm1[DIM_W-1:0]} | TIM0_RD_ONES;
    if (sel[int'(SEL_TIM1)]) rd_val = {t1_hi_q, hm1[DIM_W-1:0]};
    if (sel[int'(SEL_TIM2)]) rd_val = t2_q | TIM2_RD_ONES;
    if (sel[int'(SEL_STAT)]) rd_val = {25'd0, pal_q, 3'd0, sync_q, 1'b0, done_q};
    if (sel[int'(SEL_SUB)])  rd_val = sub_q;
  end

  assign rdata_n = rd_req ? rd_val : rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_n;
      err_q   <= bad;
    end
  end

  assign bus_rdata     = rdata_q;
  assign bus_err       = err_q;
  assign cfg_enable    = ctrl_q.en;
  assign cfg_load_mode = ctrl_q.mode;
  assign cfg_tft       = ctrl_q.tft;
  assign cfg_mono      = ctrl_q.mono;
  assign cfg_width     = width_q;
  assign cfg_height    = height_q;

  // R8: a sync error always raises the interrupt
  p_sync_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |-> irq);
  // R8: no flag set means no interrupt
  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q && !pal_q && !sync_q |-> !irq);
  // R11: the error strobe only follows a request
  p_err_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_req));
  // R12: read data holds when no read was requested
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_req) |-> $stable(bus_rdata));
endmodule

// File: tb/tb_pnl_regbank.sv
`timescale 1ns/1ps
module tb_pnl_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err, seq_start, irq, cfg_enable, cfg_tft, cfg_mono;
  logic        ev_f = 1'b0, ev_p = 1'b0, ev_s = 1'b0;
  logic [1:0]  cfg_load_mode;
  logic [10:0] cfg_width, cfg_height;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pnl_regbank dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .ev_frame_done(ev_f), .ev_palette_done(ev_p),
    .ev_sync_error(ev_s), .seq_start(seq_start), .irq(irq),
    .cfg_enable(cfg_enable), .cfg_load_mode(cfg_load_mode), .cfg_tft(cfg_tft),
    .cfg_mono(cfg_mono), .cfg_width(cfg_width), .cfg_height(cfg_height)
  );

  // behavioural reference model
  bit [1:0]  m_mode, m_ie;
  bit        m_tft, m_mono, m_en, m_done, m_pal, m_sync, m_err, m_start;
  bit        m_good, m_rise, m_fall;
  int        m_w, m_h;
  bit [31:0] m_extra, m_t0hi, m_t1hi, m_t2, m_sub, m_rd;

  function automatic bit [31:0] mread(bit [7:0] a);
    case (a)
      8'h00: return (32'(m_tft) << 23) | (32'(m_mode) << 20) | (32'(m_tft) << 7) |
                    (32'(m_ie) << 3) | (32'(m_mono) << 1) | 32'(m_en) |
                    m_extra | 32'hFE000C34;
      8'h04: return (m_t0hi << 10) | (32'(m_w - 1) & 32'h3FF) | 32'hF;
      8'h08: return (m_t1hi << 10) | (32'(m_h - 1) & 32'h3FF);
      8'h0C: return m_t2 | 32'hFC000000;
      8'h10: return (32'(m_pal) << 6) | (32'(m_sync) << 2) | 32'(m_done);
      8'h14: return m_sub;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_ie = 0; m_tft = 0; m_mono = 0; m_en = 0;
      m_done = 0; m_pal = 0; m_sync = 0; m_err = 0; m_start = 0;
      m_w = 0; m_h = 0; m_extra = 0; m_t0hi = 0; m_t1hi = 0; m_t2 = 0;
      m_sub = 0; m_rd = 0;
    end else begin
      m_good = (bus_addr[1:0] == 2'b00) && (bus_addr <= 8'h14);
      m_rise = 0; m_fall = 0;
      if (bus_req && !bus_we) m_rd = m_good ? mread(bus_addr) : 32'h0;
      m_err = bus_req && !m_good;
      if (bus_req && bus_we && m_good) begin
        case (bus_addr)
          8'h00: begin
            m_rise = bus_wdata[0] && !m_en;
            m_fall = !bus_wdata[0] && m_en;
            m_mode = bus_wdata[21:20]; m_tft = bus_wdata[7];
            m_ie = bus_wdata[4:3]; m_mono = bus_wdata[1]; m_en = bus_wdata[0];
            m_extra = bus_wdata & 32'h01CFF300;
          end
          8'h04: begin m_w = int'(bus_wdata[9:0]) + 1; m_t0hi = bus_wdata >> 10; end
          8'h08: begin m_h = int'(bus_wdata[9:0]) + 1; m_t1hi = bus_wdata >> 10; end
          8'h0C: m_t2 = bus_wdata;
          8'h14: m_sub = bus_wdata & 32'hA1FFFFFF;
          default: ;
        endcase
      end
      if (m_rise) begin m_done = 0; m_pal = 0; end
      if (m_fall) begin
        m_sync = 0;
        if (m_mode != 2'd1) m_done = 1;
      end
      m_done = m_done | ev_f;
      m_pal  = m_pal | ev_p;
      m_sync = m_sync | ev_s;
      m_start = m_rise;
    end
  end

  task automatic chk(string tag, bit [31:0] act, bit [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    chk("R12 rdata", bus_rdata, m_rd);
    chk("R11 bus_err", 32'(bus_err), 32'(m_err));
    chk("R10 seq_start", 32'(seq_start), 32'(m_start));
    chk("R8 irq", 32'(irq), 32'((m_done && m_ie[0]) || (m_pal && m_ie[1]) || m_sync));
    chk("R2 cfg_enable", 32'(cfg_enable), 32'(m_en));
    chk("R2 cfg_load_mode", 32'(cfg_load_mode), 32'(m_mode));
    chk("R2 cfg_tft", 32'(cfg_tft), 32'(m_tft));
    chk("R2 cfg_mono", 32'(cfg_mono), 32'(m_mono));
    chk("R3 cfg_width", 32'(cfg_width), 32'(m_w));
    chk("R3 cfg_height", 32'(cfg_height), 32'(m_h));
  end

  task automatic wr(bit [7:0] a, bit [31:0] d, bit f = 0, bit p = 0, bit s = 0);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    ev_f = f; ev_p = p; ev_s = s;
    @(negedge clk);
    bus_req = 0; bus_we = 0; ev_f = 0; ev_p = 0; ev_s = 0;
  endtask

  task automatic ev(bit f, bit p, bit s);
    @(negedge clk);
    ev_f = f; ev_p = p; ev_s = s;
    @(negedge clk);
    ev_f = 0; ev_p = 0; ev_s = 0;
  endtask

  task automatic rd(bit [7:0] a, bit [31:0] exp, string tag);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_req = 0;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", 32'(irq), 32'h0);
    rst_n = 1;
    rd(8'h00, 32'hFE000C34, "R1 ctrl reset");
    rd(8'h04, 32'h000003FF, "R1 tim0 reset");
    rd(8'h08, 32'h000003FF, "R1 tim1 reset");
    rd(8'h0C, 32'hFC000000, "R1 tim2 reset");
    rd(8'h10, 32'h0,        "R1 status reset");
    rd(8'h14, 32'h0,        "R1 subpanel reset");
    // bad addresses
    wr(8'h18, 32'hFFFFFFFF);
    chk("R11 err pulse", 32'(bus_err), 32'h1);
    rd(8'h18, 32'h0, "R11 high address");
    rd(8'h02, 32'h0, "R11 misaligned");
    rd(8'h00, 32'hFE000C34, "R11 no state change");
    // plain registers
    wr(8'h14, 32'hFFFFFFFF);
    rd(8'h14, 32'hA1FFFFFF, "R6 subpanel mask");
    wr(8'h04, 32'h00000C7F);
    chk("R3 width", 32'(cfg_width), 32'd128);
    rd(8'h04, 32'h00000C7F, "R3 tim0 read");
    wr(8'h08, 32'h0000A4FF);
    chk("R3 height", 32'(cfg_height), 32'd256);
    rd(8'h08, 32'h0000A4FF, "R3 tim1 read");
    wr(8'h0C, 32'h01234567);
    rd(8'h0C, 32'hFD234567, "R4 tim2 read");
    wr(8'h10, 32'hFFFFFFFF);
    rd(8'h10, 32'h0, "R5 status write ignored");
    // enable sequencing
    wr(8'h00, 32'h00000009);
    chk("R10 start after enable", 32'(seq_start), 32'h1);
    ev(0, 1, 0);
    chk("R8 palette without enable", 32'(irq), 32'h0);
    rd(8'h10, 32'h40, "R7 palette flag");
    ev(1, 0, 0);
    chk("R8 frame irq", 32'(irq), 32'h1);
    wr(8'h00, 32'h00000009);
    chk("R10 no start on same enable", 32'(seq_start), 32'h0);
    ev(0, 0, 1);
    rd(8'h10, 32'h45, "R7 all flags");
    wr(8'h00, 32'h00000000);
    rd(8'h10, 32'h41, "R9 disable clears sync sets done");
    chk("R8 irq masked", 32'(irq), 32'h0);
    wr(8'h00, 32'h00100001);
    rd(8'h10, 32'h0, "R10 enable clears flags");
    ev(0, 0, 1);
    chk("R8 sync ignores enables", 32'(irq), 32'h1);
    wr(8'h00, 32'h00100000);
    rd(8'h10, 32'h0, "R9 palette-only mode no done");
    wr(8'h00, 32'h00000011);
    ev(0, 1, 0);
    chk("R8 palette irq", 32'(irq), 32'h1);
    ev(0, 0, 1);
    wr(8'h00, 32'h00000010, 0, 0, 1);
    rd(8'h10, 32'h45, "R7 event beats clear");
    wr(8'h00, 32'h00000001, 1, 0, 0);
    rd(8'h10, 32'h05, "R7 frame event beats enable clear");
    wr(8'h00, 32'hFFFFFFFF);
    rd(8'h00, 32'hFFFFFFBF, "R2 ctrl all ones");
    chk("R2 tft", 32'(cfg_tft), 32'h1);
    wr(8'h00, 32'h00000002);
    rd(8'h00, 32'hFE000C36, "R2 mono only");
    repeat (3) @(negedge clk);
    chk("R12 rdata held", bus_rdata, 32'hFE000C36);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule